// File: doc/BRIEF.md
# I2C Quad Wiper Command Slave

This block is an I2C target that holds four 8-bit wiper settings and a small set of control flags. A controller addresses it with a 7-bit address whose upper five bits are fixed and whose lower two bits come from strap inputs. A write carries an instruction byte and may carry one data byte. The instruction byte selects a channel and can recentre that channel's register to midscale. It can also set or clear the channel's shutdown flag and set two general-purpose outputs. The optional data byte then loads the selected register. A read returns the register chosen by the most recent instruction byte.

SCL and SDA are sampled on the system clock through a synchronizer, and start and stop conditions are found from their edges. The open-drain SDA driver appears as an output enable: when the enable is high, the line is pulled low. The four register values, the shutdown flags and the two outputs are plain registered outputs for the surrounding logic.

Top module: `wiperI2cSlave`

## Requirements
- R1: After reset every wiper register holds midscale 0x80, all shutdown flags and both general outputs are 0, and sdaOe is 0.
- R2: An address byte equal to binary 0101 1, then strapAd[1], then strapAd[0], then the R/W bit (0 write, 1 read) is acknowledged: sdaOe is high during the ninth SCL pulse.
- R3: An address byte whose two low address bits differ from strapAd is not acknowledged, and the slave acknowledges nothing and changes nothing until the next start.
- R4: In the instruction byte, bits 6:5 select the channel, bit 4 requests recentring, bit 3 is the shutdown value, bit 2 drives gpOut[1] and bit 1 drives gpOut[0]; bits 7 and 0 have no effect.
- R5: A data byte following the instruction byte is acknowledged and loads the selected channel's register, which appears on wiperFlat bits [8*ch+7:8*ch]; register and flag outputs change only while SCL is low.
- R6: Bit 4 set loads 0x80 into the addressed register; when a data byte follows in the same write, the data value is what remains.
- R7: The addressed channel's shutdownOut bit takes the value of instruction bit 3, so a command with bit 3 clear releases shutdown; the register contents are not touched by it.
- R8: Instruction flags take effect once the instruction byte is acknowledged, so a stop right after the instruction byte still applies them.
- R9: A read returns the register selected by the most recent instruction byte, most significant bit first, with SDA changed by the slave only while SCL is low.
- R10: After a read byte, an acknowledge from the controller makes the slave send the same register again; a not-acknowledge makes it release SDA until the next start.
- R11: A repeated start restarts address matching, even after a mismatched address.
- R12: Any byte after the data byte within one write is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | Pull SDA low when high |
| strapAd | input | 2 | Strapped low address bits |
| wiperFlat | output | 32 | Four wiper registers, channel 0 in the low byte |
| shutdownOut | output | 4 | Per-channel shutdown flags |
| gpOut | output | 2 | General-purpose outputs |

## Verification
A wrong protocol state shows up at once as a missing or extra pull-down on SDA in the ninth clock of the byte where the state went wrong. It can also show up as corrupted read bits in the following byte. A wrong channel select or a flag misdecode appears on wiperFlat, shutdownOut or gpOut at the falling SCL edge that closes the instruction or data byte. The bench compares those outputs after every transaction, so an error is caught within the transaction that causes it.

// File: rtl/wiperPkg.sv
package wiperPkg;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 4;
  localparam int SEL_W = $clog2(NUM_CH);
  localparam logic [4:0] ADDR_PREFIX = 5'b01011;
  localparam logic [DATA_W-1:0] MID_VALUE = DATA_W'(1) << (DATA_W - 1);

  typedef struct packed {
    logic instValid;
    logic dataValid;
    logic [DATA_W-1:0] rxByte;
  } strobeT;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_TXNEXT, S_SKIP
  } stateT;
endpackage

// File: rtl/wiperSync.sv
module wiperSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/wiperCtrl.sv
module wiperCtrl
  import wiperPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic [1:0]        strap,
  input  logic [DATA_W-1:0] readByte,
  output strobeT            strobe,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  stateT             state;
  logic              sclP, sdaP;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shReg, txShift;
  logic              full, rwBit;
  logic [1:0]        byteIdx;

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
      bitCnt  <= '0;
      shReg   <= '0;
      txShift <= '0;
      full    <= 1'b0;
      rwBit   <= 1'b0;
      byteIdx <= '0;
      sdaOe   <= 1'b0;
      strobe  <= '0;
    end else begin
      sclP   <= sclS;
      sdaP   <= sdaS;
      strobe <= '0;
      if (startDet) begin
        state   <= S_RX;
        bitCnt  <= '0;
        full    <= 1'b0;
        byteIdx <= '0;
        sdaOe   <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise && !full) begin
              shReg  <= {shReg[DATA_W-2:0], sdaS};
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == CNT_W'(DATA_W - 1)) full <= 1'b1;
            end else if (sclFall && full) begin
              full   <= 1'b0;
              bitCnt <= '0;
              case (byteIdx)
                2'd0: begin
                  if (shReg[7:1] == {ADDR_PREFIX, strap}) begin
                    rwBit <= shReg[0];
                    sdaOe <= 1'b1;
                    state <= S_ACK;
                  end else begin
                    state <= S_SKIP;
                  end
                end
                2'd1: begin
                  strobe.instValid <= 1'b1;
                  strobe.rxByte    <= shReg;
                  sdaOe            <= 1'b1;
                  state            <= S_ACK;
                end
                2'd2: begin
                  strobe.dataValid <= 1'b1;
                  strobe.rxByte    <= shReg;
                  sdaOe            <= 1'b1;
                  state            <= S_ACK;
                end
                default: state <= S_SKIP;
              endcase
            end
          end
          S_ACK: begin
            if (sclFall) begin
              if (byteIdx == 2'd0 && rwBit) begin
                txShift <= readByte;
                sdaOe   <= ~readByte[DATA_W-1];
                bitCnt  <= CNT_W'(1);
                state   <= S_TX;
              end else begin
                sdaOe <= 1'b0;
                state <= S_RX;
              end
              if (byteIdx != 2'd3) byteIdx <= byteIdx + 1'b1;
            end
          end
          S_TX: begin
            if (sclFall) begin
              if (bitCnt == CNT_W'(DATA_W)) begin
                sdaOe <= 1'b0;
                state <= S_MACK;
              end else begin
                txShift <= {txShift[DATA_W-2:0], 1'b0};
                sdaOe   <= ~txShift[DATA_W-2];
                bitCnt  <= bitCnt + 1'b1;
              end
            end
          end
          S_MACK: begin
            if (sclRise) state <= sdaS ? S_SKIP : S_TXNEXT;
          end
          S_TXNEXT: begin
            if (sclFall) begin
              txShift <= readByte;
              sdaOe   <= ~readByte[DATA_W-1];
              bitCnt  <= CNT_W'(1);
              state   <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wiperDatapath.sv
module wiperDatapath
  import wiperPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   strobe,
  output logic [DATA_W-1:0]        readByte,
  output logic [NUM_CH*DATA_W-1:0] wiperFlat,
  output logic [NUM_CH-1:0]        shutdownOut,
  output logic [1:0]               gpOut
);
  logic [SEL_W-1:0] selReg;
  logic [SEL_W-1:0] instSel;
  assign instSel = strobe.rxByte[6:5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      gpOut  <= '0;
    end else if (strobe.instValid) begin
      selReg <= instSel;
      gpOut  <= {strobe.rxByte[2], strobe.rxByte[1]};
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] wReg;
    logic              sdReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wReg  <= MID_VALUE;
        sdReg <= 1'b0;
      end else if (strobe.instValid && instSel == SEL_W'(c)) begin
        sdReg <= strobe.rxByte[3];
        if (strobe.rxByte[4]) wReg <= MID_VALUE;
      end else if (strobe.dataValid && selReg == SEL_W'(c)) begin
        wReg <= strobe.rxByte;
      end
    end
    assign wiperFlat[c*DATA_W +: DATA_W] = wReg;
    assign shutdownOut[c] = sdReg;
  end

  assign readByte = wiperFlat[selReg*DATA_W +: DATA_W];
endmodule

// File: rtl/wiperI2cSlave.sv
module wiperI2cSlave
  import wiperPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  output logic                     sdaOe,
  input  logic [1:0]               strapAd,
  output logic [NUM_CH*DATA_W-1:0] wiperFlat,
  output logic [NUM_CH-1:0]        shutdownOut,
  output logic [1:0]               gpOut
);
  logic              sclS, sdaS;
  strobeT            strobe;
  logic [DATA_W-1:0] readByte;

  wiperSync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  wiperSync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  wiperCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .strap(strapAd),
    .readByte(readByte), .strobe(strobe), .sdaOe(sdaOe));

  wiperDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readByte(readByte),
    .wiperFlat(wiperFlat), .shutdownOut(shutdownOut), .gpOut(gpOut));
endmodule

// File: rtl/wiperChecker.sv
module wiperChecker
  import wiperPkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     sclIn,
  input logic                     sdaOe,
  input logic [NUM_CH*DATA_W-1:0] wiperFlat,
  input logic [NUM_CH-1:0]        shutdownOut,
  input logic [1:0]               gpOut
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (wiperFlat == {NUM_CH{MID_VALUE}} && shutdownOut == '0
                      && gpOut == '0 && !sdaOe));

  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn);

  p_wiper_scl_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wiperFlat != $past(wiperFlat)) |-> !sclIn);

  p_flags_scl_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    ({shutdownOut, gpOut} != $past({shutdownOut, gpOut})) |-> !sclIn);
endmodule

bind wiperI2cSlave wiperChecker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .wiperFlat(wiperFlat), .shutdownOut(shutdownOut), .gpOut(gpOut));

// File: tb/wiperI2cSlave_test.sv
module wiperI2cSlave_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strapAd = 2'b00;
  logic sdaOe;
  logic [31:0] wiperFlat;
  logic [3:0] shutdownOut;
  logic [1:0] gpOut;
  logic sdaLine;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] expW [4];
  logic [3:0] expSd;
  logic [1:0] expGp;
  logic [1:0] expSel;

  always #10 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  wiperI2cSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapAd(strapAd), .wiperFlat(wiperFlat), .shutdownOut(shutdownOut),
    .gpOut(gpOut));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; qwait(1); sclM = 1'b1; qwait(1);
    sdaM = 1'b0; qwait(1); sclM = 1'b0; qwait(1);
  endtask

  task automatic stopC();
    sdaM = 1'b0; qwait(1); sclM = 1'b1; qwait(1); sdaM = 1'b1; qwait(2);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; qwait(1); sclM = 1'b1; qwait(2); sclM = 1'b0; qwait(1);
    end
    sdaM = 1'b1; qwait(1); sclM = 1'b1; qwait(1);
    ack = ~sdaLine;
    qwait(1); sclM = 1'b0; qwait(1);
  endtask

  task automatic readByte(output logic [7:0] b, input logic mAck);
    b = '0;
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qwait(1); sclM = 1'b1; qwait(1); b = {b[6:0], sdaLine}; qwait(1);
      sclM = 1'b0; qwait(1);
    end
    sdaM = ~mAck; qwait(1); sclM = 1'b1; qwait(2); sclM = 1'b0; qwait(1);
    sdaM = 1'b1;
  endtask

  function automatic logic [7:0] addrByte(input logic [1:0] ad, input logic rd);
    return {5'b01011, ad, rd};
  endfunction

  function automatic void modelInst(input logic [7:0] b);
    expSel = b[6:5];
    if (b[4]) expW[b[6:5]] = 8'h80;
    expSd[b[6:5]] = b[3];
    expGp = {b[2], b[1]};
  endfunction

  task automatic checkAll(input string req);
    chk({req, " wiperFlat"}, wiperFlat, {expW[3], expW[2], expW[1], expW[0]});
    chk({req, " shutdownOut"}, {28'd0, shutdownOut}, {28'd0, expSd});
    chk({req, " gpOut"}, {30'd0, gpOut}, {30'd0, expGp});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    for (int c = 0; c < 4; c++) expW[c] = 8'h80;
    expSd = '0; expGp = '0; expSel = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll("R1");
    chk("R1 sdaOe", {31'd0, sdaOe}, 32'd0);

    // R2, R3, R5: strap and address sweep
    for (int s = 0; s < 4; s++) begin
      strapAd = 2'(s);
      for (int a = 0; a < 4; a++) begin
        logic [7:0] inst;
        logic [7:0] d;
        logic match;
        match = (a == s);
        inst = {1'b0, 2'(a), 5'b00000};
        d = 8'(s * 37 + a * 11 + 5);
        startC();
        writeByte(addrByte(2'(a), 1'b0), ack);
        chk(match ? "R2 addr ack" : "R3 addr nack", {31'd0, ack}, {31'd0, match});
        writeByte(inst, ack);
        chk("R3 inst ack", {31'd0, ack}, {31'd0, match});
        writeByte(d, ack);
        chk("R5 data ack", {31'd0, ack}, {31'd0, match});
        stopC();
        if (match) begin
          modelInst(inst);
          expW[a] = d;
        end
        checkAll(match ? "R5" : "R3");
      end
    end

    // R4, R6, R7, R8: instruction-only writes, all flags on every channel
    strapAd = 2'b10;
    for (int ch = 0; ch < 4; ch++) begin
      for (int f = 0; f < 16; f++) begin
        logic [7:0] inst;
        logic [3:0] fb;
        fb = 4'(f);
        inst = {fb[0], 2'(ch), fb[3], fb[2], fb[1], fb[0], ~fb[1]};
        startC();
        writeByte(addrByte(2'b10, 1'b0), ack);
        writeByte(inst, ack);
        chk("R8 inst ack", {31'd0, ack}, 32'd1);
        stopC();
        modelInst(inst);
        checkAll("R4 R6 R7 R8");
      end
    end

    // R6: recentre then data in one write, data wins
    for (int ch = 0; ch < 4; ch++) begin
      logic [7:0] inst;
      logic [7:0] d;
      inst = {1'b0, 2'(ch), 5'b10000};
      d = 8'(8'h3C + ch * 29);
      startC();
      writeByte(addrByte(2'b10, 1'b0), ack);
      writeByte(inst, ack);
      writeByte(d, ack);
      stopC();
      modelInst(inst);
      expW[ch] = d;
      checkAll("R6");
    end

    // R9, R10: select, read twice with ack then nack, then released
    for (int ch = 0; ch < 4; ch++) begin
      logic [7:0] inst;
      inst = {1'b0, 2'(ch), 5'b00000};
      startC();
      writeByte(addrByte(2'b10, 1'b0), ack);
      writeByte(inst, ack);
      modelInst(inst);
      startC();
      writeByte(addrByte(2'b10, 1'b1), ack);
      chk("R2 read addr ack", {31'd0, ack}, 32'd1);
      readByte(rb, 1'b1);
      chk("R9 read byte", {24'd0, rb}, {24'd0, expW[ch]});
      readByte(rb, 1'b0);
      chk("R10 repeat after ack", {24'd0, rb}, {24'd0, expW[ch]});
      readByte(rb, 1'b1);
      chk("R10 released after nack", {24'd0, rb}, 32'hFF);
      stopC();
      checkAll("R9");
    end

    // R11: mismatch then repeated start with a matching address
    startC();
    writeByte(addrByte(2'b01, 1'b0), ack);
    chk("R11 first addr nack", {31'd0, ack}, 32'd0);
    writeByte(8'b0_01_00000, ack);
    startC();
    writeByte(addrByte(2'b10, 1'b0), ack);
    chk("R11 restart ack", {31'd0, ack}, 32'd1);
    writeByte(8'b0_01_00000, ack);
    writeByte(8'h5A, ack);
    stopC();
    modelInst(8'b0_01_00000);
    expW[1] = 8'h5A;
    checkAll("R11");

    // R12: extra byte after data
    startC();
    writeByte(addrByte(2'b10, 1'b0), ack);
    writeByte(8'b0_11_00000, ack);
    writeByte(8'hC3, ack);
    writeByte(8'h3C, ack);
    chk("R12 extra nack", {31'd0, ack}, 32'd0);
    stopC();
    modelInst(8'b0_11_00000);
    expW[3] = 8'hC3;
    checkAll("R12");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule